// File: doc/BRIEF.md
# Return Address Shadow Stack Monitor

This block sits next to a processor's control-flow unit and protects procedure returns from corrupted return addresses. When a call executes, the block forms the return address (the current PC plus the instruction size) and keeps a private copy of it in a small hardware stack. The software cannot reach this stack. The block also produces the call target, which is the current PC plus a sign-extended offset, and a link-register write carrying the return address.

When a return executes, the control-flow unit presents the target it loaded from the in-memory stack. The monitor pops its private copy and compares the two values. The PC write is granted only when they are equal. When they differ, or when no private copy is left, the PC write is withheld and the block raises a single-cycle trap that marks a likely buffer overflow.

Every result is registered and appears one clock after the strobe. Two sticky flags record that a trap or a stack overflow has happened since the last clear. An overflow here means a push that found the private stack full.

Top module: `retaddr_guard`

## Requirements
- R1: After reset, `pc_we_o`, `lr_we_o`, `trap_o`, `trap_flag_o` and `ovf_flag_o` are all 0.
- R2: One cycle after a call strobe, the block outputs the following. `pc_we_o`=1 with `pc_wdata_o` = `pc_i` + sign-extended `offs_i`. `lr_we_o`=1 with `lr_wdata_o` = `pc_i` + RA_INC, where RA_INC defaults to 2.
- R3: One cycle after a return strobe whose `mem_tgt_i` equals the newest address still held, the block outputs `pc_we_o`=1 and `pc_wdata_o`=`mem_tgt_i`, with `trap_o`=0 and `lr_we_o`=0.
- R4: One cycle after a return strobe whose `mem_tgt_i` differs from the newest held address, `pc_we_o`=0 and `trap_o`=1 for exactly that one cycle. The held entry is consumed anyway.
- R5: Nested calls are checked in last-in first-out order.
- R6: A return strobe while the private stack is empty produces a trap and no PC write.
- R7: A push onto a full stack (DEPTH entries, default 32) discards the oldest entry and sets `ovf_flag_o`. The DEPTH newest addresses still match in reverse order, and the return after them traps.
- R8: `trap_flag_o` goes to 1 with every trap and stays there until `clr_i`. If a trap and `clr_i` occur in the same cycle, the flag stays at 1.
- R9: `ovf_flag_o` stays at 1 until `clr_i` is applied.
- R10: If `call_i` and `ret_i` are both high in one cycle, only the return is processed. There is no push and no link write.
- R11: A negative offset (most significant bit of `offs_i` set) yields a call target below `pc_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | Call strobe, one cycle per call |
| ret_i | input | 1 | Return strobe, one cycle per return |
| pc_i | input | AW | PC of the call instruction |
| offs_i | input | OW | Signed call offset |
| mem_tgt_i | input | AW | Return target read from the memory stack |
| clr_i | input | 1 | Clears both sticky flags |
| pc_we_o | output | 1 | PC write grant |
| pc_wdata_o | output | AW | New PC value |
| lr_we_o | output | 1 | Link register write |
| lr_wdata_o | output | AW | Return address for the link register |
| trap_o | output | 1 | One-cycle trap pulse |
| trap_flag_o | output | 1 | Sticky trap flag |
| ovf_flag_o | output | 1 | Sticky shadow-stack overflow flag |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:
- A mismatch followed by a second return shows whether a failed check still consumes its entry. A design that kept the entry would check the second return against a stale address instead of trapping on empty.
- Overfilling the stack by three, then unwinding, catches a pointer that fails to wrap. That fault shows up as false traps on the newest addresses, or as no trap once the discarded ones are reached.
- Issuing a call and a return together, and a clear together with a trap, exposes a wrong priority. The design would then grow the stack or drop a trap record.
- A negative offset catches a target adder that zero-extends, which sends the jump far forward.

// File: rtl/retaddr_guard_pkg.sv
package retaddr_guard_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_CALL = 2'd1,
    OP_RET  = 2'd2
  } guard_op_e;

  // Return strobe has priority; a simultaneous call is dropped.
  function automatic guard_op_e decode_op(input logic call, input logic ret);
    if (ret)       return OP_RET;
    else if (call) return OP_CALL;
    else           return OP_IDLE;
  endfunction

endpackage

// File: rtl/retaddr_guard_stack.sv
module retaddr_guard_stack #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned AW    = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] top_o,
  output logic          empty_o,
  output logic          ovf_o
);

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [PW-1:0] wr_q, wr_d, rd_idx;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full;
  logic [AW-1:0] slot_w [DEPTH];

  assign full    = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);
  assign ovf_o   = push_i && full;
  assign rd_idx  = (wr_q == '0) ? LAST_IDX : (wr_q - PW'(1));
  assign top_o   = slot_w[rd_idx];

  // Circular write pointer: a push on a full stack overwrites the oldest slot.
  always_comb begin
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (push_i) begin
      wr_d = (wr_q == LAST_IDX) ? '0 : (wr_q + PW'(1));
      if (!full) cnt_d = cnt_q + CW'(1);
    end else if (pop_i && !empty_o) begin
      wr_d  = rd_idx;
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic          slot_en;
      logic [AW-1:0] slot_q;
      assign slot_en = push_i && (wr_q == PW'(g));
      always_ff @(posedge clk_i) begin
        if (slot_en) slot_q <= wdata_i;
      end
      assign slot_w[g] = slot_q;
    end
  endgenerate

endmodule

// File: rtl/retaddr_guard_eval.sv
module retaddr_guard_eval
  import retaddr_guard_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned OW     = 12,
  parameter int unsigned RA_INC = 2
) (
  input  guard_op_e     op_i,
  input  logic          empty_i,
  input  logic [AW-1:0] top_i,
  input  logic [AW-1:0] mem_tgt_i,
  input  logic [AW-1:0] pc_i,
  input  logic [OW-1:0] offs_i,
  output logic          push_o,
  output logic          pop_o,
  output logic          match_o,
  output logic          trap_o,
  output logic [AW-1:0] ra_o,
  output logic [AW-1:0] tgt_o
);

  logic          is_ret;
  logic [AW-1:0] offs_ext;

  assign offs_ext = {{(AW-OW){offs_i[OW-1]}}, offs_i};
  assign ra_o     = pc_i + AW'(RA_INC);
  assign tgt_o    = pc_i + offs_ext;

  assign is_ret  = (op_i == OP_RET);
  assign push_o  = (op_i == OP_CALL);
  assign pop_o   = is_ret && !empty_i;
  assign match_o = is_ret && !empty_i && (top_i == mem_tgt_i);
  assign trap_o  = is_ret && !match_o;

endmodule

// File: rtl/retaddr_guard_outs.sv
module retaddr_guard_outs #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          call_i,
  input  logic          match_i,
  input  logic          trap_i,
  input  logic          ovf_i,
  input  logic          clr_i,
  input  logic [AW-1:0] tgt_i,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] mem_tgt_i,
  output logic          pc_we_o,
  output logic [AW-1:0] pc_wdata_o,
  output logic          lr_we_o,
  output logic [AW-1:0] lr_wdata_o,
  output logic          trap_o,
  output logic          trap_flag_o,
  output logic          ovf_flag_o
);

  logic          pc_we_d, lr_we_d, trap_d, tflag_d, oflag_d;
  logic [AW-1:0] pc_wd_d;

  always_comb begin
    pc_we_d = call_i || match_i;
    pc_wd_d = call_i ? tgt_i : mem_tgt_i;
    lr_we_d = call_i;
    trap_d  = trap_i;
    // New events win over a clear in the same cycle.
    tflag_d = trap_i || (trap_flag_o && !clr_i);
    oflag_d = ovf_i  || (ovf_flag_o  && !clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_we_o     <= 1'b0;
      lr_we_o     <= 1'b0;
      trap_o      <= 1'b0;
      trap_flag_o <= 1'b0;
      ovf_flag_o  <= 1'b0;
    end else begin
      pc_we_o     <= pc_we_d;
      lr_we_o     <= lr_we_d;
      trap_o      <= trap_d;
      trap_flag_o <= tflag_d;
      ovf_flag_o  <= oflag_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_wdata_o <= '0;
      lr_wdata_o <= '0;
    end else begin
      if (pc_we_d) pc_wdata_o <= pc_wd_d;
      if (lr_we_d) lr_wdata_o <= ra_i;
    end
  end

endmodule

// File: rtl/retaddr_guard.sv
module retaddr_guard
  import retaddr_guard_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned OW     = 12,
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned RA_INC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic [AW-1:0] pc_i,
  input  logic [OW-1:0] offs_i,
  input  logic [AW-1:0] mem_tgt_i,
  input  logic          clr_i,
  output logic          pc_we_o,
  output logic [AW-1:0] pc_wdata_o,
  output logic          lr_we_o,
  output logic [AW-1:0] lr_wdata_o,
  output logic          trap_o,
  output logic          trap_flag_o,
  output logic          ovf_flag_o
);

  guard_op_e     op;
  logic          push, pop, match, trap, empty, ovf;
  logic [AW-1:0] top, ra, tgt;

  assign op = decode_op(call_i, ret_i);

  retaddr_guard_stack #(.DEPTH(DEPTH), .AW(AW)) u_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .wdata_i (ra),
    .top_o   (top),
    .empty_o (empty),
    .ovf_o   (ovf)
  );

  retaddr_guard_eval #(.AW(AW), .OW(OW), .RA_INC(RA_INC)) u_eval (
    .op_i      (op),
    .empty_i   (empty),
    .top_i     (top),
    .mem_tgt_i (mem_tgt_i),
    .pc_i      (pc_i),
    .offs_i    (offs_i),
    .push_o    (push),
    .pop_o     (pop),
    .match_o   (match),
    .trap_o    (trap),
    .ra_o      (ra),
    .tgt_o     (tgt)
  );

  retaddr_guard_outs #(.AW(AW)) u_outs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .call_i      (push),
    .match_i     (match),
    .trap_i      (trap),
    .ovf_i       (ovf),
    .clr_i       (clr_i),
    .tgt_i       (tgt),
    .ra_i        (ra),
    .mem_tgt_i   (mem_tgt_i),
    .pc_we_o     (pc_we_o),
    .pc_wdata_o  (pc_wdata_o),
    .lr_we_o     (lr_we_o),
    .lr_wdata_o  (lr_wdata_o),
    .trap_o      (trap_o),
    .trap_flag_o (trap_flag_o),
    .ovf_flag_o  (ovf_flag_o)
  );

endmodule

// File: rtl/retaddr_guard_chk.sv
module retaddr_guard_chk #(
  parameter int unsigned AW     = 32,
  parameter int unsigned RA_INC = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          call_i,
  input logic          ret_i,
  input logic [AW-1:0] pc_i,
  input logic [AW-1:0] mem_tgt_i,
  input logic          clr_i,
  input logic          pc_we_o,
  input logic [AW-1:0] pc_wdata_o,
  input logic          lr_we_o,
  input logic [AW-1:0] lr_wdata_o,
  input logic          trap_o,
  input logic          trap_flag_o,
  input logic          ovf_flag_o
);

  a_r4_trap_from_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(ret_i));

  a_r4_no_pc_on_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trap_o && pc_we_o));

  a_r2_link_from_call: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lr_we_o |-> ($past(call_i) && !$past(ret_i) && pc_we_o &&
                 lr_wdata_o == $past(pc_i) + AW'(RA_INC)));

  a_r3_return_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_we_o && !lr_we_o) |-> ($past(ret_i) && pc_wdata_o == $past(mem_tgt_i)));

  a_r8_trap_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> trap_flag_o);

  a_r8_flag_needs_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(trap_flag_o) |-> $past(clr_i));

  a_r9_ovf_needs_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovf_flag_o) |-> $past(clr_i));

endmodule

bind retaddr_guard retaddr_guard_chk #(.AW(AW), .RA_INC(RA_INC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .call_i      (call_i),
  .ret_i       (ret_i),
  .pc_i        (pc_i),
  .mem_tgt_i   (mem_tgt_i),
  .clr_i       (clr_i),
  .pc_we_o     (pc_we_o),
  .pc_wdata_o  (pc_wdata_o),
  .lr_we_o     (lr_we_o),
  .lr_wdata_o  (lr_wdata_o),
  .trap_o      (trap_o),
  .trap_flag_o (trap_flag_o),
  .ovf_flag_o  (ovf_flag_o)
);

// File: tb/sim_retaddr_guard.sv
`timescale 1ns/1ps
module sim_retaddr_guard;

  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        call_i, ret_i, clr_i;
  logic [31:0] pc_i, mem_tgt_i;
  logic [11:0] offs_i;
  logic        pc_we_o, lr_we_o, trap_o, trap_flag_o, ovf_flag_o;
  logic [31:0] pc_wdata_o, lr_wdata_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  retaddr_guard u0 (
    .clk_i(clk), .rst_ni(rst_ni), .call_i(call_i), .ret_i(ret_i),
    .pc_i(pc_i), .offs_i(offs_i), .mem_tgt_i(mem_tgt_i), .clr_i(clr_i),
    .pc_we_o(pc_we_o), .pc_wdata_o(pc_wdata_o), .lr_we_o(lr_we_o),
    .lr_wdata_o(lr_wdata_o), .trap_o(trap_o), .trap_flag_o(trap_flag_o),
    .ovf_flag_o(ovf_flag_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive for one cycle; results are visible at the following falling edge.
  task automatic do_call(input logic [31:0] pc, input logic [11:0] off);
    call_i = 1'b1; pc_i = pc; offs_i = off;
    @(negedge clk);
    call_i = 1'b0;
  endtask

  task automatic do_ret(input logic [31:0] tgt);
    ret_i = 1'b1; mem_tgt_i = tgt;
    @(negedge clk);
    ret_i = 1'b0;
  endtask

  task automatic do_clr();
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 pc_we", {31'd0, pc_we_o}, 32'd0);
    check("R1 lr_we", {31'd0, lr_we_o}, 32'd0);
    check("R1 trap", {31'd0, trap_o}, 32'd0);
    check("R1 flags", {30'd0, trap_flag_o, ovf_flag_o}, 32'd0);
  endtask

  task automatic t_call_ret();
    do_call(32'h0000_1000, 12'h040);
    check("R2 pc_we", {31'd0, pc_we_o}, 32'd1);
    check("R2 target", pc_wdata_o, 32'h0000_1040);
    check("R2 lr_we", {31'd0, lr_we_o}, 32'd1);
    check("R2 link", lr_wdata_o, 32'h0000_1002);
    do_ret(32'h0000_1002);
    check("R3 pc_we", {31'd0, pc_we_o}, 32'd1);
    check("R3 pc", pc_wdata_o, 32'h0000_1002);
    check("R3 no trap", {31'd0, trap_o}, 32'd0);
    check("R3 no link", {31'd0, lr_we_o}, 32'd0);
  endtask

  task automatic t_negoff();
    do_call(32'h0000_2000, 12'hFFC);
    check("R11 target", pc_wdata_o, 32'h0000_1FFC);
    do_ret(32'h0000_2002);
    check("R11 ret ok", {31'd0, pc_we_o}, 32'd1);
  endtask

  task automatic t_nested();
    for (int k = 1; k <= 5; k++) do_call(32'h100 * k, 12'h010);
    for (int k = 5; k >= 1; k--) begin
      do_ret(32'h100 * k + 2);
      check("R5 match", {31'd0, pc_we_o}, 32'd1);
      check("R5 pc", pc_wdata_o, 32'h100 * k + 2);
    end
  endtask

  task automatic t_mismatch();
    do_call(32'h0000_3000, 12'h020);
    do_ret(32'h0000_3004);
    check("R4 trap", {31'd0, trap_o}, 32'd1);
    check("R4 no pc", {31'd0, pc_we_o}, 32'd0);
    @(negedge clk);
    check("R4 pulse", {31'd0, trap_o}, 32'd0);
    check("R8 sticky", {31'd0, trap_flag_o}, 32'd1);
    do_ret(32'h0000_3002);
    check("R6 empty trap", {31'd0, trap_o}, 32'd1);
    check("R6 empty no pc", {31'd0, pc_we_o}, 32'd0);
    do_clr();
    check("R8 cleared", {31'd0, trap_flag_o}, 32'd0);
  endtask

  task automatic t_clr_vs_trap();
    clr_i = 1'b1;
    do_ret(32'h0000_0000);
    clr_i = 1'b0;
    check("R8 set beats clr", {31'd0, trap_flag_o}, 32'd1);
    do_clr();
    check("R8 cleared again", {31'd0, trap_flag_o}, 32'd0);
  endtask

  task automatic t_overflow();
    for (int k = 0; k < DEPTH; k++) do_call(32'h4000 + 4 * k, 12'h000);
    check("R7 no ovf at full", {31'd0, ovf_flag_o}, 32'd0);
    for (int k = DEPTH; k < DEPTH + 3; k++) do_call(32'h4000 + 4 * k, 12'h000);
    check("R7 ovf set", {31'd0, ovf_flag_o}, 32'd1);
    for (int k = DEPTH + 2; k >= 3; k--) begin
      do_ret(32'h4000 + 4 * k + 2);
      check("R7 newest kept", {31'd0, pc_we_o}, 32'd1);
    end
    do_ret(32'h4000 + 4 * 2 + 2);
    check("R7 oldest dropped", {31'd0, trap_o}, 32'd1);
    check("R9 ovf held", {31'd0, ovf_flag_o}, 32'd1);
    do_clr();
    check("R9 ovf cleared", {31'd0, ovf_flag_o}, 32'd0);
  endtask

  task automatic t_both();
    do_call(32'h0000_5000, 12'h004);
    call_i = 1'b1; pc_i = 32'h0000_6000;
    do_ret(32'h0000_5002);
    call_i = 1'b0;
    check("R10 ret wins", pc_wdata_o, 32'h0000_5002);
    check("R10 no link", {31'd0, lr_we_o}, 32'd0);
    do_ret(32'h0000_6002);
    check("R10 no push", {31'd0, trap_o}, 32'd1);
    do_clr();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; call_i = 1'b0; ret_i = 1'b0; clr_i = 1'b0;
    pc_i = '0; offs_i = '0; mem_tgt_i = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_call_ret();
    t_negoff();
    t_nested();
    t_mismatch();
    t_clr_vs_trap();
    t_overflow();
    t_both();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule